// File: doc/BRIEF.md
# Coarse/Fine Table Sine Generator

This block synthesises a sampled sine wave by phase accumulation. On every sample strobe a phase register advances by a tuning word and wraps modulo its width. The phase is split into a coarse part and a fine part. A coarse table holds one full period of sine. The same table is read a second time, a quarter period further on, to obtain the cosine of the coarse angle. A fine table holds the sine of the small residual angles that lie between two coarse points.

The output is formed as sin(coarse) + sin(fine)·cos(coarse). The cosine of the fine angle is treated as exactly one, which is valid when the fine step is small against the output precision. The output frequency is Fs·tune/(N·n), where N and n are the two table depths.

A host write port can reload either table at run time. This lets the contents, and so the effective waveform and scaling, change without rebuilding the block. The datapath has two stages, a table read followed by a multiply-add. Both stages advance only on sample strobes.

Top module: `sine_cf_gen`

## Requirements
- R1: After reset `sampleOut` is 0, `sampleValid` is 0 and the phase register is 0.
- R2: Each cycle with `sampleStb` high advances the phase by `tuneWord`, wrapping modulo 2^(COARSE_W+FINE_W). The first strobe after reset uses phase 0.
- R3: The upper COARSE_W bits of the phase index the coarse table. The lower FINE_W bits index the fine table.
- R4: The sample for a phase is coarse[c] + scaled(fine[f] · coarse[(c + N/4) mod N]), where N = 2^COARSE_W.
- R5: The cosine read address (c + N/4) wraps modulo N for the coarse indices in the last quarter of the table.
- R6: The product of two Q1.(SAMP_W-1) values is scaled by an arithmetic shift right of SAMP_W-1 after adding 2^(SAMP_W-2), so an exact half rounds toward plus infinity.
- R7: The sum saturates to the signed SAMP_W-bit range. With SAMP_W = 14 that range is -8192 to 8191.
- R8: The sample for the phase used at strobe k is presented on the clock edge of strobe k+1, with `sampleValid` high for that one cycle. The first strobe after reset produces no valid sample.
- R9: In cycles without `sampleStb`, the phase, `sampleOut` and the pipeline contents do not change, and `sampleValid` is low.
- R10: A cycle with `wrEn` high writes `wrData` to entry `wrAddr` of the coarse table when `wrSel` is 0, or to the fine table when `wrSel` is 1. For the fine table only the low FINE_W bits of the address are used. Later reads return the new value. Reset does not clear the tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | Sample strobe; advances phase and pipeline |
| tuneWord | input | COARSE_W+FINE_W | Phase increment per strobe |
| wrEn | input | 1 | Table write enable |
| wrSel | input | 1 | Table select: 0 coarse, 1 fine |
| wrAddr | input | COARSE_W | Table write address |
| wrData | input | SAMP_W | Table write data, signed |
| sampleOut | output | SAMP_W | Signed sine sample |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench builds the block with COARSE_W = 4, FINE_W = 3 and SAMP_W = 14. This gives a 16-entry coarse table, an 8-entry fine table and a 7-bit phase, so every table entry can be loaded and every phase reached within a few dozen strobes. The small coarse depth means a short run already visits the last quarter, where the cosine address wraps. Tuning words of 127 and 13 exercise phase wraparound and mixed coarse/fine steps. Full 14-bit sample width is kept, so rounding ties and both saturation limits are reached with hand-picked table entries.

// File: rtl/sine_cf_pkg.sv
package sine_cf_pkg;

  // Strobes sent from control to datapath each cycle.
  typedef struct packed {
    logic capStb;   // load table read registers
    logic macStb;   // compute and present a sample
  } ctrl_strobe_t;

  typedef enum logic {
    TBL_COARSE = 1'b0,
    TBL_FINE   = 1'b1
  } tbl_sel_e;

endpackage

// File: rtl/sine_cf_ctrl.sv
module sine_cf_ctrl
  import sine_cf_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleStb,
  input  logic [COARSE_W+FINE_W-1:0]   tuneWord,
  output ctrl_strobe_t                 strobes,
  output logic [COARSE_W-1:0]          coarseIdx,
  output logic [FINE_W-1:0]            fineIdx
);

  localparam int PHASE_W = COARSE_W + FINE_W;

  logic [PHASE_W-1:0] phaseAcc;
  logic               stage1Full;

  // Phase accumulator, wraps naturally at PHASE_W bits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
    end else if (sampleStb) begin
      phaseAcc <= phaseAcc + tuneWord;
    end
  end

  // Tracks whether the read stage holds a captured phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Full <= 1'b0;
    end else if (sampleStb) begin
      stage1Full <= 1'b1;
    end
  end

  always_comb begin
    strobes.capStb = sampleStb;
    strobes.macStb = sampleStb & stage1Full;
  end

  assign coarseIdx = phaseAcc[PHASE_W-1 -: COARSE_W];
  assign fineIdx   = phaseAcc[FINE_W-1:0];

  // R9: phase holds without a strobe
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(phaseAcc));

  // R8: the MAC stage never fires on the first strobe after reset
  a_r8_no_mac_empty: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && $past(!rstN)) |-> !strobes.macStb);

endmodule

// File: rtl/sine_cf_table.sv
module sine_cf_table #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 14,
  parameter bit DUAL_RD = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Contents survive reset; only the host port changes them.
  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataA <= '0;
    end else if (rdEn) begin
      rdDataA <= mem[rdAddrA];
    end
  end

  generate
    if (DUAL_RD) begin : g_dual
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdDataB <= '0;
        end else if (rdEn) begin
          rdDataB <= mem[rdAddrB];
        end
      end
    end else begin : g_single
      logic unusedAddrB;
      assign unusedAddrB = ^rdAddrB;
      assign rdDataB     = '0;
    end
  endgenerate

endmodule

// File: rtl/sine_cf_datapath.sv
module sine_cf_datapath
  import sine_cf_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 7,
  parameter int SAMP_W   = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobes,
  input  logic [COARSE_W-1:0] coarseIdx,
  input  logic [FINE_W-1:0]   fineIdx,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [COARSE_W-1:0] wrAddr,
  input  logic [SAMP_W-1:0]   wrData,
  output logic [SAMP_W-1:0]   sampleOut,
  output logic                sampleValid
);

  localparam int PROD_W = 2 * SAMP_W;
  localparam int SUM_W  = SAMP_W + 2;
  localparam logic [COARSE_W-1:0] QUARTER = COARSE_W'(1) << (COARSE_W - 2);
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (SAMP_W - 2);
  localparam logic signed [SUM_W-1:0] SAT_MAX = SUM_W'((1 << (SAMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_MIN = SUM_W'(-(1 << (SAMP_W - 1)));

  tbl_sel_e selIn;
  logic     coarseWe;
  logic     fineWe;
  logic [COARSE_W-1:0] cosIdx;

  assign selIn    = tbl_sel_e'(wrSel);
  assign coarseWe = wrEn && (selIn == TBL_COARSE);
  assign fineWe   = wrEn && (selIn == TBL_FINE);
  // Quarter-period offset; the add wraps modulo the table depth.
  assign cosIdx   = coarseIdx + QUARTER;

  logic [SAMP_W-1:0] sinCoarse;
  logic [SAMP_W-1:0] cosCoarse;
  logic [SAMP_W-1:0] sinFine;
  logic [SAMP_W-1:0] fineSpare;

  sine_cf_table #(
    .ADDR_W (COARSE_W),
    .DATA_W (SAMP_W),
    .DUAL_RD(1'b1)
  ) coarse_tbl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (strobes.capStb),
    .rdAddrA(coarseIdx),
    .rdAddrB(cosIdx),
    .wrEn   (coarseWe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdDataA(sinCoarse),
    .rdDataB(cosCoarse)
  );

  sine_cf_table #(
    .ADDR_W (FINE_W),
    .DATA_W (SAMP_W),
    .DUAL_RD(1'b0)
  ) fine_tbl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (strobes.capStb),
    .rdAddrA(fineIdx),
    .rdAddrB(fineIdx),
    .wrEn   (fineWe),
    .wrAddr (wrAddr[FINE_W-1:0]),
    .wrData (wrData),
    .rdDataA(sinFine),
    .rdDataB(fineSpare)
  );

  logic unusedFineSpare;
  assign unusedFineSpare = ^fineSpare;

  // Multiply-add stage.
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] productRnd;
  logic signed [PROD_W-1:0] productScaled;
  logic signed [SUM_W-1:0]  sumWide;
  logic [SAMP_W-1:0]        satVal;

  always_comb begin
    product       = PROD_W'($signed(sinFine)) * PROD_W'($signed(cosCoarse));
    productRnd    = product + HALF_LSB;
    productScaled = productRnd >>> (SAMP_W - 1);
    sumWide       = SUM_W'($signed(sinCoarse)) + $signed(productScaled[SUM_W-1:0]);
    if (sumWide > SAT_MAX) begin
      satVal = SAT_MAX[SAMP_W-1:0];
    end else if (sumWide < SAT_MIN) begin
      satVal = SAT_MIN[SAMP_W-1:0];
    end else begin
      satVal = sumWide[SAMP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.macStb;
      if (strobes.macStb) begin
        sampleOut <= satVal;
      end
    end
  end

  // R8: a valid sample only follows a strobe
  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(strobes.capStb));

  // R9: output holds when the MAC stage is idle
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.macStb |=> $stable(sampleOut));

  // R7: positive overflow lands on the upper limit
  a_r7_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.macStb && (sumWide > SAT_MAX)) |=> (sampleOut == SAT_MAX[SAMP_W-1:0]));

  // R7: negative overflow lands on the lower limit
  a_r7_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.macStb && (sumWide < SAT_MIN)) |=> (sampleOut == SAT_MIN[SAMP_W-1:0]));

  // R5: cosine address sits a quarter period after the sine address
  a_r5_cos_offset: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capStb |-> (COARSE_W'(cosIdx - coarseIdx) == QUARTER));

endmodule

// File: rtl/sine_cf_gen.sv
module sine_cf_gen
  import sine_cf_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 7,
  parameter int SAMP_W   = 14
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleStb,
  input  logic [COARSE_W+FINE_W-1:0]   tuneWord,
  input  logic                         wrEn,
  input  logic                         wrSel,
  input  logic [COARSE_W-1:0]          wrAddr,
  input  logic [SAMP_W-1:0]            wrData,
  output logic [SAMP_W-1:0]            sampleOut,
  output logic                         sampleValid
);

  ctrl_strobe_t        strobes;
  logic [COARSE_W-1:0] coarseIdx;
  logic [FINE_W-1:0]   fineIdx;

  sine_cf_ctrl #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleStb(sampleStb),
    .tuneWord (tuneWord),
    .strobes  (strobes),
    .coarseIdx(coarseIdx),
    .fineIdx  (fineIdx)
  );

  sine_cf_datapath #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W),
    .SAMP_W  (SAMP_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .coarseIdx  (coarseIdx),
    .fineIdx    (fineIdx),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/sine_cf_gen_tb.sv
module sine_cf_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COARSE_W = 4;
  localparam int FINE_W   = 3;
  localparam int SAMP_W   = 14;
  localparam int PHASE_W  = COARSE_W + FINE_W;
  localparam int NC = 1 << COARSE_W;
  localparam int NF = 1 << FINE_W;
  localparam int NVEC = 5;

  typedef struct packed {
    logic [PHASE_W-1:0] tune;
    logic [7:0]         strobes;
  } vec_t;

  // tune 1: fine walk (R3); tune 8: pure coarse steps through last quarter (R5);
  // tune 13: mixed steps; tune 127: wraparound (R2); tune 0: constant output.
  localparam vec_t VECS [NVEC] = '{
    '{tune: 7'd1,   strobes: 8'd12},
    '{tune: 7'd8,   strobes: 8'd20},
    '{tune: 7'd13,  strobes: 8'd24},
    '{tune: 7'd127, strobes: 8'd12},
    '{tune: 7'd0,   strobes: 8'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic [PHASE_W-1:0] tuneWord = '0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [COARSE_W-1:0] wrAddr = '0;
  logic [SAMP_W-1:0] wrData = '0;
  logic [SAMP_W-1:0] sampleOut;
  logic sampleValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int coarseM [NC];
  int fineM [NF];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sine_cf_gen #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W),
    .SAMP_W  (SAMP_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .tuneWord(tuneWord),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int modelSample(int ph);
    int c, f, prod, sum;
    c = ph >> FINE_W;
    f = ph % NF;
    prod = fineM[f] * coarseM[(c + NC/4) % NC];
    sum = coarseM[c] + ((prod + 4096) >>> 13);
    if (sum > 8191) sum = 8191;
    if (sum < -8192) sum = -8192;
    return sum;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic strobe();
    @(negedge clk);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic writeTbl(bit sel, int addr, int val);
    @(negedge clk);
    wrEn = 1'b1;
    wrSel = sel;
    wrAddr = COARSE_W'(addr);
    wrData = SAMP_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) fineM[addr] = val; else coarseM[addr] = val;
  endtask

  // Runs tune=1 from reset and returns the sample for phase 1 (c=0, f=1).
  task automatic phaseOneSample(output int s);
    doReset();
    tuneWord = 7'd1;
    repeat (3) strobe();
    s = $signed(sampleOut);
  endtask

  initial begin
    int ph, prevPh, s, held;
    doReset();
    // R1: reset state
    check("R1 out", int'($signed(sampleOut)), 0);
    check("R1 valid", int'(sampleValid), 0);

    // R10: load both tables through the host port (wrSel 0 coarse, 1 fine)
    for (int i = 0; i < NC; i++)
      writeTbl(1'b0, i, int'($rtoi($floor(8191.0 * $sin(2.0 * 3.14159265358979 * i / NC) + 0.5))));
    for (int j = 0; j < NF; j++)
      writeTbl(1'b1, j, int'($rtoi($floor(8191.0 * $sin(2.0 * 3.14159265358979 * j / (NC * NF)) + 0.5))));

    // R2 R3 R4 R5 R8: vector walk
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      tuneWord = VECS[v].tune;
      ph = 0;
      prevPh = 0;
      for (int k = 0; k < int'(VECS[v].strobes); k++) begin
        strobe();
        if (k == 0) begin
          check("R8 first strobe no valid", int'(sampleValid), 0);
        end else begin
          check("R8 valid", int'(sampleValid), 1);
          check("R4 sample", int'($signed(sampleOut)), modelSample(prevPh));
        end
        prevPh = ph;
        ph = (ph + int'(VECS[v].tune)) % (1 << PHASE_W);
      end
      if (v == 2) begin
        // R9: idle cycles hold everything
        held = $signed(sampleOut);
        repeat (6) @(negedge clk);
        check("R9 valid low", int'(sampleValid), 0);
        check("R9 out held", int'($signed(sampleOut)), held);
        strobe();
        check("R9 phase held", int'($signed(sampleOut)), modelSample(prevPh));
      end
    end

    // R10: table contents survive reset and new values are used
    writeTbl(1'b0, 0, 100);
    writeTbl(1'b0, 4, 4096);
    writeTbl(1'b1, 1, 1);
    phaseOneSample(s);
    check("R10 rewritten table", s, modelSample(1));
    // R6: 1*4096 = half LSB, rounds up -> 100 + 1
    check("R6 round half up", s, 101);
    writeTbl(1'b1, 1, -1);
    phaseOneSample(s);
    check("R6 minus half rounds to 0", s, 100);
    writeTbl(1'b1, 1, -2);
    phaseOneSample(s);
    check("R6 minus one", s, 99);

    // R7: saturation both ways
    writeTbl(1'b0, 0, 8000);
    writeTbl(1'b0, 4, 8191);
    writeTbl(1'b1, 1, 8191);
    phaseOneSample(s);
    check("R7 sat high", s, 8191);
    writeTbl(1'b0, 0, -8000);
    writeTbl(1'b1, 1, -8191);
    phaseOneSample(s);
    check("R7 sat low", s, -8192);

    // R1: reset clears output again
    doReset();
    check("R1 out after rerun", int'($signed(sampleOut)), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule